// File: doc/BRIEF.md
# Bidirectional Display Column Driver Core

This block is the logic core of a 64-column driver for a plasma display panel. Display data arrives four bits per clock over four 1-bit lanes. Each lane feeds its own 16-stage shift register. The 64 stages are numbered S1 to S64 and are interleaved across the lanes: lane k (k = 1..4) holds stages k, k+4, k+8 and so on up to k+60.

A direction input decides which of the two 4-bit ports accepts data and which one passes the data on toward the next device in a chain. The port that is not passing data on has its output enable low, so that several devices can be chained B-to-A.

A latch bank takes a snapshot of all 64 stages on a clock edge while the latch enable is high. Each latched bit then passes through an output stage. In that stage a blanking input forces every column to the level of the polarity input. With blanking low, the polarity input either passes the latched data or inverts it.

Top module: `column_driver_core`

## Requirements
- R1: A synchronous reset, high on a rising clock edge, clears all 64 stages and the latch to zero. After reset, both cascade outputs read 0, and with `blank`=0 and `pol`=1 every column reads 0.
- R2: With `dir_right`=1, each rising edge moves S(n) to S(n+4) and loads S1..S4 from `a_in[0]..a_in[3]`. After 16 edges, stage S(4p+k) holds bit k-1 of the word applied at edge 16-p, counting from 1 (p = 0..15, k = 1..4).
- R3: With `dir_right`=1, `b_out[k-1]` shows stage S(60+k), so a word applied to `a_in` appears on `b_out` after the 16th edge that follows it.
- R4: With `dir_right`=0, each rising edge moves S(n+4) to S(n) and loads S61..S64 from `b_in[0]..b_in[3]`. After 16 edges, stage S(4p+k) holds bit k-1 of the word applied at edge p+1.
- R5: With `dir_right`=0, `a_out[k-1]` shows stage S(k), so a word applied to `b_in` appears on `a_out` after the 16th edge that follows it.
- R6: With `dir_right`=1, `b_oe`=1 and `a_oe`=0. With `dir_right`=0, `a_oe`=1 and `b_oe`=0.
- R7: On a rising edge with `lat_en`=1, the latch captures the stage values as they stood just before that edge's shift.
- R8: On an edge with `lat_en`=0, the latch keeps its contents, so the columns do not change while the stages keep shifting.
- R9: With `blank`=1, every bit of `col` equals `pol`, whatever the latch holds.
- R10: With `blank`=0, `col[n-1]` equals latched stage Sn when `pol`=1, and its inverse when `pol`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; shifting and latching happen on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| dir_right | input | 1 | 1: shift from port A toward port B; 0: from B toward A |
| lat_en | input | 1 | Latch load enable |
| blank | input | 1 | Forces all columns to the `pol` level |
| pol | input | 1 | 1: columns follow the latch; 0: columns are inverted |
| a_in | input | 4 | Port A data in (used when `dir_right`=1) |
| a_out | output | 4 | Port A data out, stages S1..S4 |
| a_oe | output | 1 | Port A output enable |
| b_in | input | 4 | Port B data in (used when `dir_right`=0) |
| b_out | output | 4 | Port B data out, stages S61..S64 |
| b_oe | output | 1 | Port B output enable |
| col | output | 64 | Column levels; bit n-1 belongs to stage Sn |

## Verification
Each direction is filled with 16 words from three patterns, and each pattern exposes a different class of fault:
- An ascending count makes every word distinct, so a wrong shift order or a wrong lane-to-stage mapping shows up as a misplaced word.
- An alternating 5/A pattern with an offset exposes swapped or crossed lanes.
- A walking one isolates single-bit stuck or dropped stages.

After each fill, the latched image is viewed through all four blank and polarity combinations. Further shifting with the latch disabled shows that the columns hold. The cascade port is compared with the first and second words applied, which ties the delay to exactly 16 edges.

// File: rtl/cdrv_pkg.sv
package cdrv_pkg;

  // Flat stage index (0-based) of lane `lane` (0-based) at depth `pos`.
  function automatic int stage_idx(input int lane, input int pos, input int lanes);
    return pos * lanes + lane;
  endfunction

  // Level of one column given its latched bit and the blank/polarity controls.
  function automatic logic col_level(input logic latched, input logic blank, input logic pol);
    logic lvl;
    if (blank) lvl = pol;
    else       lvl = pol ? latched : ~latched;
    return lvl;
  endfunction

endpackage

// File: rtl/cdrv_lane.sv
module cdrv_lane #(
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dir_right,
  input  logic             a_bit,
  input  logic             b_bit,
  output logic [DEPTH-1:0] q
);
  // q[0] sits next to port A, q[DEPTH-1] next to port B.
  logic shift_r_ev;
  logic shift_l_ev;
  assign shift_r_ev = !rst && dir_right;
  assign shift_l_ev = !rst && !dir_right;

  always_ff @(posedge clk) begin
    if (rst)             q <= '0;
    else if (shift_r_ev) q <= {q[DEPTH-2:0], a_bit};
    else if (shift_l_ev) q <= {b_bit, q[DEPTH-1:1]};
  end

  // R2: right shift loads the A-side stage from the A lane
  a_r2_load_a: assert property (@(posedge clk) disable iff (rst)
    dir_right |=> q[0] == $past(a_bit));
  // R4: left shift loads the B-side stage from the B lane
  a_r4_load_b: assert property (@(posedge clk) disable iff (rst)
    !dir_right |=> q[DEPTH-1] == $past(b_bit));
  // R2: data leaving the A-side stage lands one stage deeper
  a_r2_advance: assert property (@(posedge clk) disable iff (rst)
    dir_right |=> q[1] == $past(q[0]));
  // R4: data leaving the B-side stage lands one stage nearer A
  a_r4_advance: assert property (@(posedge clk) disable iff (rst)
    !dir_right |=> q[DEPTH-2] == $past(q[DEPTH-1]));
endmodule

// File: rtl/cdrv_latch.sv
module cdrv_latch #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic load_ev;
  assign load_ev = !rst && load;

  always_ff @(posedge clk) begin
    if (rst)          q <= '0;
    else if (load_ev) q <= d;
  end

  // R7: a load edge captures the pre-edge stage image
  a_r7_capture: assert property (@(posedge clk) disable iff (rst)
    load |=> q == $past(d));
  // R8: without load the latch holds
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !load |=> q == $past(q));
endmodule

// File: rtl/cdrv_outstage.sv
module cdrv_outstage #(
  parameter int W = 64
) (
  input  logic         blank,
  input  logic         pol,
  input  logic [W-1:0] lat,
  output logic [W-1:0] col
);
  import cdrv_pkg::*;

  for (genvar n = 0; n < W; n++) begin : g_col
    assign col[n] = col_level(lat[n], blank, pol);
  end
endmodule

// File: rtl/column_driver_core.sv
module column_driver_core #(
  parameter int LANES = 4,
  parameter int DEPTH = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   dir_right,
  input  logic                   lat_en,
  input  logic                   blank,
  input  logic                   pol,
  input  logic [LANES-1:0]       a_in,
  output logic [LANES-1:0]       a_out,
  output logic                   a_oe,
  input  logic [LANES-1:0]       b_in,
  output logic [LANES-1:0]       b_out,
  output logic                   b_oe,
  output logic [LANES*DEPTH-1:0] col
);
  import cdrv_pkg::*;

  localparam int NSTG = LANES * DEPTH;

  logic [DEPTH-1:0] lane_q [LANES];
  logic [NSTG-1:0]  stage;
  logic [NSTG-1:0]  latch_q;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    cdrv_lane #(.DEPTH(DEPTH)) u_lane (
      .clk      (clk),
      .rst      (rst),
      .dir_right(dir_right),
      .a_bit    (a_in[k]),
      .b_bit    (b_in[k]),
      .q        (lane_q[k])
    );
    for (genvar p = 0; p < DEPTH; p++) begin : g_pos
      assign stage[stage_idx(k, p, LANES)] = lane_q[k][p];
    end
    assign a_out[k] = lane_q[k][0];
    assign b_out[k] = lane_q[k][DEPTH-1];
  end

  assign b_oe = dir_right;
  assign a_oe = !dir_right;

  cdrv_latch #(.W(NSTG)) u_latch (
    .clk (clk),
    .rst (rst),
    .load(lat_en),
    .d   (stage),
    .q   (latch_q)
  );

  cdrv_outstage #(.W(NSTG)) u_out (
    .blank(blank),
    .pol  (pol),
    .lat  (latch_q),
    .col  (col)
  );

  // R9: blanking forces every column to the polarity level
  a_r9_blank: assert property (@(posedge clk) disable iff (rst)
    blank |-> col == {NSTG{pol}});
  // R10: unblanked, true polarity shows the latch
  a_r10_pass: assert property (@(posedge clk) disable iff (rst)
    (!blank && pol) |-> col == latch_q);
  // R10: unblanked, inverted polarity shows the complement
  a_r10_invert: assert property (@(posedge clk) disable iff (rst)
    (!blank && !pol) |-> col == ~latch_q);
  // R6: exactly one port drives at a time
  a_r6_one_driver: assert property (@(posedge clk) disable iff (rst)
    $countones({a_oe, b_oe}) == 1);
  // R1: cleared stages right after reset
  a_r1_clear: assert property (@(posedge clk)
    rst |=> (stage == '0 && latch_q == '0));
endmodule

// File: tb/column_driver_core_test.sv
module column_driver_core_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        dir_right = 1'b1;
  logic        lat_en = 1'b0;
  logic        blank = 1'b0;
  logic        pol = 1'b1;
  logic [3:0]  a_in = '0;
  logic [3:0]  b_in = '0;
  logic [3:0]  a_out, b_out;
  logic        a_oe, b_oe;
  logic [63:0] col;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  column_driver_core uut (
    .clk(clk), .rst(rst), .dir_right(dir_right), .lat_en(lat_en),
    .blank(blank), .pol(pol), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe), .col(col)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000) begin
      errors++;
      $display("FAIL watchdog: run did not finish (got %0d cycles, expected < 20000)", cyc);
      $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  function automatic logic [3:0] pat(input int seed, input int t);
    case (seed)
      0:       return 4'(t);
      1:       return (t % 2 == 1) ? 4'(4'hA ^ 4'(t)) : 4'(4'h5 ^ 4'(t));
      default: return 4'(1 << (t % 4));
    endcase
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk64(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic chk4(input string req, input logic [3:0] got, input logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic run_fill(input logic right, input int seed);
    logic [63:0] img;
    dir_right = right;
    lat_en = 1'b0;
    blank = 1'b0;
    pol = 1'b1;
    #1;
    if (right) begin
      chk4("R6 oe right", {2'b0, a_oe, b_oe}, 4'b0001);
    end else begin
      chk4("R6 oe left", {2'b0, a_oe, b_oe}, 4'b0010);
    end
    for (int t = 0; t < 16; t++) begin
      if (right) a_in = pat(seed, t);
      else       b_in = pat(seed, t);
      step();
    end
    // expected image from R2 / R4
    for (int p = 0; p < 16; p++) begin
      for (int k = 0; k < 4; k++) begin
        img[p*4 + k] = right ? pat(seed, 15 - p)[k] : pat(seed, p)[k];
      end
    end
    if (right) chk4("R3 cascade first word", b_out, pat(seed, 0));
    else       chk4("R5 cascade first word", a_out, pat(seed, 0));
    // latch on the next edge: captures pre-shift image (R7)
    lat_en = 1'b1;
    a_in = 4'h0;
    b_in = 4'h0;
    step();
    lat_en = 1'b0;
    #1;
    if (right) chk4("R3 cascade second word", b_out, pat(seed, 1));
    else       chk4("R5 cascade second word", a_out, pat(seed, 1));
    chk64(right ? "R2/R7/R10 image right" : "R4/R7/R10 image left", col, img);
    pol = 1'b0; #1;
    chk64("R10 inverted image", col, ~img);
    blank = 1'b1; #1;
    chk64("R9 blank low", col, 64'h0);
    pol = 1'b1; #1;
    chk64("R9 blank high", col, {64{1'b1}});
    blank = 1'b0; #1;
    // R8: keep shifting with latch disabled
    for (int t = 0; t < 5; t++) begin
      a_in = 4'hF; b_in = 4'hF;
      step();
    end
    chk64("R8 hold while shifting", col, img);
  endtask

  initial begin
    @(negedge clk);
    a_in = 4'hF; b_in = 4'hF;
    step();
    step();
    rst = 1'b0;
    #1;
    chk64("R1 columns after reset", col, 64'h0);
    chk4("R1 port A after reset", a_out, 4'h0);
    chk4("R1 port B after reset", b_out, 4'h0);
    pol = 1'b0; #1;
    chk64("R1/R10 inverted after reset", col, {64{1'b1}});
    pol = 1'b1;
    for (int s = 0; s < 3; s++) begin
      run_fill(1'b1, s);
      run_fill(1'b0, s);
    end
    // R1: reset again clears a loaded latch
    rst = 1'b1;
    step();
    rst = 1'b0;
    blank = 1'b0; pol = 1'b1; #1;
    chk64("R1 columns after second reset", col, 64'h0);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule